// File: doc/BRIEF.md
# Input Glitch and Debounce Filter

This block conditions the input side of a general-purpose I/O port of up to 32 lines. Every line is first brought into the system clock domain by a two-stage synchronizer. After that, the line either goes straight to the pin-data output or passes through one of two filters. The fast filter runs on every system clock and removes single-cycle spikes. The slow filter samples on a divided slow-clock time base and removes contact bounce.

Software controls each line through four write-one masks. Two of them turn filtering on or off. The other two pick glitch mode or debounce mode. A bit written as zero leaves that line unchanged. One shared divider value sets how far apart the debounce samples are. The divided slow clock has a period of (DIV+1)×2 slow-clock periods, and the filter samples on both of its half-period boundaries. Software usually derives DIV from the slow-clock rate as rate/(2×cutoff) − 1. The slow clock reaches the block as a one-cycle strobe `slow_tick` in the system clock domain.

Top module: `pin_input_filter`

## Requirements
- R1: While reset is held, and on the first cycle after it is released with `pin_in` at zero, `en_status`, `mode_status` and `pin_data` are all zero.
- R2: A one in `en_set` turns filtering on for that line. A one in `en_clr` turns it off. Zero bits change nothing. If both are set for the same line in one cycle, the line ends up unfiltered. `en_status` shows the new state one clock after the write.
- R3: `mode_status` bit = 1 means debounce mode and 0 means glitch mode. A one in `mode_debounce_wr` selects debounce and a one in `mode_glitch_wr` selects glitch. Zero bits change nothing. If both are written for the same line in one cycle, debounce wins. The new state shows one clock later.
- R4: On a line whose `en_status` bit is 0, `pin_data` equals the value `pin_in` had two clock edges earlier.
- R5: In glitch mode a synchronized level reaches `pin_data` only after it has been seen on two consecutive clocks. A steady change appears 4 edges after it is applied. A pulse one clock wide is dropped. A pulse two clocks wide passes.
- R6: Debounce samples are taken once every DIV+1 `slow_tick` strobes, which is half of the (DIV+1)×2 divided period. The output of a debounce line changes only at a sample, and only to a level that was also seen at the previous sample. Writing `div_val` with `div_wr` restarts the count.
- R7: In debounce mode a pulse shorter than DIV+1 slow strobes is dropped. So one pulse width can pass at DIV = 0 and be dropped at DIV = 4.
- R8: When a filtered line is disabled, its `pin_data` follows the synchronized input from the next cycle on, and keeps no filter history.
- R9: Lines are independent. With the same pulse on every line, glitch-mode lines pass a 3-clock pulse while debounce-mode lines drop it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| pin_in | input | LINES | Raw line levels, asynchronous |
| en_set | input | LINES | Write-one mask that enables filtering |
| en_clr | input | LINES | Write-one mask that disables filtering |
| mode_glitch_wr | input | LINES | Write-one mask that selects glitch mode |
| mode_debounce_wr | input | LINES | Write-one mask that selects debounce mode |
| div_wr | input | 1 | Load strobe for the debounce divider |
| div_val | input | DIV_W | Divider value DIV |
| pin_data | output | LINES | Conditioned line levels for pin-data reads |
| en_status | output | LINES | Current filter-enable mask |
| mode_status | output | LINES | Current mode mask, 1 = debounce |

## Verification
Some properties are checked on every cycle. These are the two-edge latency of unfiltered lines, the priority rules of the mask writes, the rule that a glitch line changes only to a level held on two consecutive synchronized samples, the rule that debounce lines change only right after a sample, and the spacing of the samples in slow strobes. Other behaviour shows only in the bench's timed scenarios: the exact edge on which a glitch change appears, whether a pulse of a given width passes or is dropped under two different divider values, side-by-side behaviour of lines in different modes, and the immediate switch back to the direct path.

// File: rtl/pif_pkg.sv
package pif_pkg;
   typedef enum logic {
      FILT_GLITCH   = 1'b0,
      FILT_DEBOUNCE = 1'b1
   } filt_mode_e;

   localparam int SYNC_STAGES = 2;
   localparam int MAX_LINES   = 32;
   localparam int MAX_DIV_W   = 16;
endpackage

// File: rtl/pif_sync.sv
module pif_sync #(
   parameter int LINES  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pif_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][LINES-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pif_cfg.sv
module pif_cfg #(
   parameter int LINES = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] en_set,
   input  logic [LINES-1:0] en_clr,
   input  logic [LINES-1:0] mode_glitch_wr,
   input  logic [LINES-1:0] mode_debounce_wr,
   output logic [LINES-1:0] en_q,
   output logic [LINES-1:0] mode_q
);
   logic [LINES-1:0] en_next;
   logic [LINES-1:0] mode_next;

   // disable beats enable; debounce beats glitch
   always_comb begin
      en_next   = (en_q | en_set) & ~en_clr;
      mode_next = (mode_q & ~mode_glitch_wr) | mode_debounce_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mode_q <= '0;
      end else begin
         en_q   <= en_next;
         mode_q <= mode_next;
      end
   end
endmodule

// File: rtl/pif_divider.sv
module pif_divider #(
   parameter int DIV_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_val,
   output logic [DIV_W-1:0] div_q,
   output logic             sample_tick
);
   logic [DIV_W-1:0] cnt_q;
   logic             hit;

   assign hit         = (cnt_q == div_q);
   assign sample_tick = slow_tick & hit & ~div_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (div_wr) begin
         div_q <= div_val;
         cnt_q <= '0;
      end else if (slow_tick) begin
         cnt_q <= hit ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pif_line.sv
module pif_line
   import pif_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic sample_tick,
   input  logic filt_en,
   input  logic mode_bit,
   output logic data_out
);
   logic       gl_prev_q, gl_out_q;
   logic       db_prev_q, db_out_q;
   filt_mode_e mode;

   assign mode = filt_mode_e'(mode_bit);

   // fast path: two agreeing samples on consecutive system clocks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gl_prev_q <= 1'b0;
         gl_out_q  <= 1'b0;
      end else begin
         gl_prev_q <= sync_in;
         if (sync_in == gl_prev_q) gl_out_q <= sync_in;
      end
   end

   // slow path: two agreeing samples on consecutive half-period ticks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         db_prev_q <= 1'b0;
         db_out_q  <= 1'b0;
      end else if (sample_tick) begin
         db_prev_q <= sync_in;
         if (sync_in == db_prev_q) db_out_q <= sync_in;
      end
   end

   always_comb begin
      if (!filt_en)                   data_out = sync_in;
      else if (mode == FILT_DEBOUNCE) data_out = db_out_q;
      else                            data_out = gl_out_q;
   end
endmodule

// File: rtl/pin_input_filter.sv
module pin_input_filter
   import pif_pkg::*;
#(
   parameter int LINES = 32,
   parameter int DIV_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic [LINES-1:0] pin_in,
   input  logic [LINES-1:0] en_set,
   input  logic [LINES-1:0] en_clr,
   input  logic [LINES-1:0] mode_glitch_wr,
   input  logic [LINES-1:0] mode_debounce_wr,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_val,
   output logic [LINES-1:0] pin_data,
   output logic [LINES-1:0] en_status,
   output logic [LINES-1:0] mode_status
);
   if (LINES < 1 || LINES > MAX_LINES) begin : g_bad_lines
      $error("pin_input_filter: LINES out of range");
   end
   if (DIV_W < 1 || DIV_W > MAX_DIV_W) begin : g_bad_div
      $error("pin_input_filter: DIV_W out of range");
   end

   logic [LINES-1:0] sync_q;
   logic [DIV_W-1:0] div_q;
   logic             deb_tick;

   pif_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (sync_q)
   );

   pif_cfg #(.LINES(LINES)) u_cfg (
      .clk             (clk),
      .rst_n           (rst_n),
      .en_set          (en_set),
      .en_clr          (en_clr),
      .mode_glitch_wr  (mode_glitch_wr),
      .mode_debounce_wr(mode_debounce_wr),
      .en_q            (en_status),
      .mode_q          (mode_status)
   );

   pif_divider #(.DIV_W(DIV_W)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_tick  (slow_tick),
      .div_wr     (div_wr),
      .div_val    (div_val),
      .div_q      (div_q),
      .sample_tick(deb_tick)
   );

   for (genvar i = 0; i < LINES; i++) begin : g_line
      pif_line u_line (
         .clk        (clk),
         .rst_n      (rst_n),
         .sync_in    (sync_q[i]),
         .sample_tick(deb_tick),
         .filt_en    (en_status[i]),
         .mode_bit   (mode_status[i]),
         .data_out   (pin_data[i])
      );
   end
endmodule

// File: rtl/pif_checker.sv
module pif_checker #(
   parameter int LINES = 32,
   parameter int DIV_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slow_tick,
   input logic             div_wr,
   input logic [LINES-1:0] pin_in,
   input logic [LINES-1:0] en_set,
   input logic [LINES-1:0] en_clr,
   input logic [LINES-1:0] mode_glitch_wr,
   input logic [LINES-1:0] mode_debounce_wr,
   input logic [LINES-1:0] pin_data,
   input logic [LINES-1:0] en_status,
   input logic [LINES-1:0] mode_status,
   input logic [LINES-1:0] sync_q,
   input logic [DIV_W-1:0] div_q,
   input logic             deb_tick
);
   logic [1:0]       age_q;
   logic [DIV_W-1:0] strobes_q;
   logic [LINES-1:0] gl_lines, db_lines;

   assign gl_lines = en_status & ~mode_status;
   assign db_lines = en_status & mode_status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= '0;
      else if (age_q != 2'd3)  age_q <= age_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    strobes_q <= '0;
      else if (div_wr || deb_tick)   strobes_q <= '0;
      else if (slow_tick)            strobes_q <= strobes_q + 1'b1;
   end

   p_en_clr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd0) |-> ((en_status & $past(en_clr)) == '0));

   p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd0) |-> (($past(en_set) & ~$past(en_clr) & ~en_status) == '0));

   p_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd0) |->
      ((($past(mode_debounce_wr) & ~mode_status) |
        ($past(mode_glitch_wr) & ~$past(mode_debounce_wr) & mode_status)) == '0));

   p_bypass_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2) |-> (((pin_data ^ $past(pin_in, 2)) & ~en_status) == '0));

   p_glitch_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3) |->
      (((pin_data ^ $past(pin_data)) & gl_lines & $past(gl_lines) &
        ((pin_data ^ $past(sync_q)) | ($past(sync_q) ^ $past(sync_q, 2)))) == '0));

   p_debounce_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && !$past(deb_tick)) |->
      (((pin_data ^ $past(pin_data)) & db_lines & $past(db_lines)) == '0));

   p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      deb_tick |-> (strobes_q == div_q));
endmodule

bind pin_input_filter pif_checker #(.LINES(LINES), .DIV_W(DIV_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .slow_tick       (slow_tick),
   .div_wr          (div_wr),
   .pin_in          (pin_in),
   .en_set          (en_set),
   .en_clr          (en_clr),
   .mode_glitch_wr  (mode_glitch_wr),
   .mode_debounce_wr(mode_debounce_wr),
   .pin_data        (pin_data),
   .en_status       (en_status),
   .mode_status     (mode_status),
   .sync_q          (sync_q),
   .div_q           (div_q),
   .deb_tick        (deb_tick)
);

// File: tb/pin_input_filter_tb.sv
module pin_input_filter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LINES      = 32;
   localparam int DIV_W      = 14;
   localparam int SLOW_RATIO = 4;
   localparam logic [31:0] ALL = 32'hFFFF_FFFF;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             slow_tick;
   logic [LINES-1:0] pin_in = '0;
   logic [LINES-1:0] en_set = '0, en_clr = '0;
   logic [LINES-1:0] mode_glitch_wr = '0, mode_debounce_wr = '0;
   logic             div_wr = 1'b0;
   logic [DIV_W-1:0] div_val = '0;
   logic [LINES-1:0] pin_data, en_status, mode_status;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;
   int slow_cnt = 0;

   logic [31:0] en_m = '0, mode_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) slow_cnt <= (slow_cnt == SLOW_RATIO-1) ? 0 : slow_cnt + 1;
   assign slow_tick = (slow_cnt == 0);

   pin_input_filter #(.LINES(LINES), .DIV_W(DIV_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .pin_in(pin_in),
      .en_set(en_set), .en_clr(en_clr), .mode_glitch_wr(mode_glitch_wr),
      .mode_debounce_wr(mode_debounce_wr), .div_wr(div_wr), .div_val(div_val),
      .pin_data(pin_data), .en_status(en_status), .mode_status(mode_status)
   );

   function automatic logic [31:0] next_en(logic [31:0] cur, logic [31:0] s, logic [31:0] c);
      return (cur | s) & ~c;
   endfunction

   function automatic logic [31:0] next_mode(logic [31:0] cur, logic [31:0] g, logic [31:0] d);
      return (cur & ~g) | d;
   endfunction

   task automatic tick(int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg(logic [31:0] s, logic [31:0] c, logic [31:0] g, logic [31:0] d);
      en_set = s; en_clr = c; mode_glitch_wr = g; mode_debounce_wr = d;
      en_m   = next_en(en_m, s, c);
      mode_m = next_mode(mode_m, g, d);
      tick(1);
      en_set = '0; en_clr = '0; mode_glitch_wr = '0; mode_debounce_wr = '0;
   endtask

   task automatic set_div(int v);
      div_wr = 1'b1; div_val = DIV_W'(v);
      tick(1);
      div_wr = 1'b0;
   endtask

   task automatic watch(int n, output logic [31:0] seen);
      seen = '0;
      for (int i = 0; i < n; i++) begin
         tick(1);
         seen |= pin_data;
      end
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      logic [31:0] a, b, m, v, prev, seen;
      void'($urandom(32'h5EED_0042));

      // R1: reset state
      tick(3);
      check("R1 en during reset", en_status, '0);
      check("R1 mode during reset", mode_status, '0);
      check("R1 data during reset", pin_data, '0);
      rst_n = 1'b1;
      tick(1);
      check("R1 en after release", en_status, '0);
      check("R1 data after release", pin_data, '0);

      // R2 / R3: random mask writes with overlaps, zero bits inert
      for (int i = 0; i < 40; i++) begin
         logic [31:0] s, c, g, d;
         s = $urandom; c = $urandom & $urandom; g = $urandom; d = $urandom & $urandom;
         if (i == 0) begin s = ALL; c = 32'h0000_FFFF; g = ALL; d = 32'h00FF_00FF; end
         cfg(s, c, g, d);
         check("R2 enable mask", en_status, en_m);
         check("R3 mode mask", mode_status, mode_m);
      end

      // R4: direct path, two-edge latency
      cfg('0, ALL, '0, '0);
      pin_in = '0;
      tick(3);
      prev = '0;
      for (int i = 0; i < 20; i++) begin
         v = $urandom;
         pin_in = v;
         tick(1);
         check("R4 not yet after one edge", pin_data, prev);
         tick(1);
         check("R4 after two edges", pin_data, v);
         prev = v;
      end

      // R5: glitch mode
      cfg(ALL, '0, ALL, '0);
      a = $urandom;
      pin_in = a;
      tick(6);
      check("R5 settled", pin_data, a);
      m = $urandom | 32'h1;
      b = a ^ m;
      pin_in = b;
      tick(1);
      pin_in = a;
      for (int i = 0; i < 6; i++) begin
         tick(1);
         check("R5 one-clock pulse dropped", pin_data, a);
      end
      pin_in = b;
      tick(2);
      pin_in = a;
      tick(1);
      check("R5 two-clock pulse edge3", pin_data, a);
      tick(1);
      check("R5 two-clock pulse edge4", pin_data, b);
      tick(1);
      check("R5 two-clock pulse edge5", pin_data, b);
      tick(1);
      check("R5 two-clock pulse edge6", pin_data, a);
      tick(4);
      pin_in = b;
      tick(3);
      check("R5 steady change edge3", pin_data, a);
      tick(1);
      check("R5 steady change edge4", pin_data, b);

      // R6: debounce at DIV=0 passes a 12-clock pulse
      cfg('0, '0, '0, ALL);
      set_div(0);
      pin_in = '0;
      tick(40);
      check("R6 debounce settled low", pin_data, '0);
      m = $urandom | 32'h8000_0001;
      pin_in = m;
      tick(12);
      pin_in = '0;
      watch(30, seen);
      check("R6 DIV=0 pulse seen", seen, m);
      check("R6 DIV=0 returns low", pin_data, '0);

      // R7: same pulse dropped at DIV=4, long hold accepted
      set_div(4);
      tick(60);
      pin_in = m;
      seen = '0;
      for (int i = 0; i < 12; i++) begin
         tick(1);
         seen |= pin_data;
      end
      pin_in = '0;
      begin
         logic [31:0] rest;
         watch(60, rest);
         seen |= rest;
      end
      check("R7 DIV=4 short pulse dropped", seen, '0);
      pin_in = m;
      tick(70);
      check("R7 DIV=4 long hold accepted", pin_data, m);
      pin_in = '0;
      tick(70);
      check("R7 DIV=4 long low accepted", pin_data, '0);

      // R9: mixed modes on the same pulse
      cfg('0, '0, 32'hAAAA_AAAA, 32'h5555_5555);
      check("R9 mode mask", mode_status, 32'h5555_5555);
      tick(60);
      pin_in = ALL;
      tick(3);
      pin_in = '0;
      watch(60, seen);
      check("R9 glitch lines pass, debounce lines drop", seen, 32'hAAAA_AAAA);

      // R8: disable drops straight to the direct path
      cfg('0, '0, '0, ALL);
      tick(60);
      v = $urandom | 32'h1;
      pin_in = v;
      tick(5);
      check("R8 debounce still holding old level", pin_data, '0);
      cfg('0, ALL, '0, '0);
      check("R8 enable cleared", en_status, '0);
      check("R8 direct path immediately", pin_data, v);

      summary();
   end
endmodule